// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full / Expansion-Out Flag

This block is a first-in first-out buffer of 9-bit words whose write side and read side run on independent clocks. A word is stored on a rising write clock edge while the active-low write strobe is low. The oldest stored word is fetched into an output register on a rising read clock edge while the active-low read strobe is low. The data pins are driven only while the read strobe is low and float otherwise. Empty and full flags prevent underrun and overrun. The depth is a parameter: one of 256, 512, 1024, 2048 or 4096.

Each side keeps a binary pointer one bit wider than the address. Each pointer crosses to the other domain as a registered Gray code through two flops. The write side runs a three-state machine: `WS_LOWER` (occupancy at or below half), `WS_UPPER` (above half, not full) and `WS_FULL`. Every write clock it takes whichever transition the next occupancy selects: lower-to-upper, upper-to-full, full-to-upper, upper-to-lower, or a direct lower-to-full jump after a rewind. The read side runs `RS_EMPTY`, `RS_DATA` and `RS_REWIND`. Its transitions are empty-to-data when the synchronized write pointer moves ahead, data-to-empty on the read that takes the last word, any-to-rewind when a retransmit is requested, and rewind-to-empty or rewind-to-data when the retransmit input is released.

A mode input selects what the dual-role flag pin carries. In standalone use it shows half-full. In chained depth expansion it gives a one-clock hand-off pulse to the next device when this buffer takes its last free word. Retransmit is honoured only in standalone use. It rewinds the read pointer to word 0 so that every word written since reset is replayed.

Top module: `rtx_fifo`

## Requirements
- R1: Words (9 bits) are read out in exactly the order they were written, for any interleaving of the two clocks.
- R2: A write happens at a rising `wclk` edge where `wr_n` is 0 and `full` is 0, and it stores `din`.
- R3: A read happens at a rising `rclk` edge where `rd_n` is 0 and `empty` is 0. The next word appears on `q` after that edge while `rd_n` stays 0.
- R4: A write while `full` is 1 stores nothing and overwrites nothing. A read while `empty` is 1 moves no pointer and leaves `q` unchanged.
- R5: `q` is high impedance and `q_drive` is 0 whenever `rd_n` is 1. While `rd_n` is 0, `q_drive` is 1.
- R6: `full` rises right after the write edge that brings the occupancy to DEPTH. `empty` rises right after the read edge that takes the last word. Each flag clears only after the other side's pointer has crossed the synchronizer.
- R7: With `link_en` = 0, `hf_xo` is 1 while the occupancy is strictly greater than DEPTH/2 and 0 at DEPTH/2 or below.
- R8: With `link_en` = 0, holding `rt_n` at 0 while `rd_n` is 1 resets the read pointer to word 0 and reports `empty` = 1 until `rt_n` returns to 1. Reads then replay every word written since reset. This holds when no more than DEPTH words have been written since reset.
- R9: With `link_en` = 1, `hf_xo` pulses 1 for exactly one `wclk` cycle after the write that fills the buffer and is otherwise 0. `rt_n` is ignored.
- R10: While `rst_n` is 0, both pointers clear, `empty` = 1, `full` = 0, `hf_xo` = 0 and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low master reset for both sides |
| wr_n | input | 1 | Active-low write strobe, sampled on `wclk` |
| din | input | 9 | Write data |
| rd_n | input | 1 | Active-low read strobe, sampled on `rclk`; also the output enable |
| rt_n | input | 1 | Active-low retransmit request, sampled on `rclk` |
| link_en | input | 1 | 1 = depth-expansion chain mode, 0 = standalone |
| q | output | 9 | Read data, high impedance while `rd_n` is 1 |
| q_drive | output | 1 | 1 while `q` is driven |
| empty | output | 1 | No word available to read (read domain) |
| full | output | 1 | No free word for writing (write domain) |
| hf_xo | output | 1 | Half-full flag, or expansion-out pulse when `link_en` is 1 |

## Verification
The assertions assume that `rt_n` is lowered only while `rd_n` is 1 and while writes are idle. They also assume that `link_en` changes only under reset, and that no more than DEPTH words have been written before a retransmit. The stimulus changes strobes only at the falling edge of their own clock. It resets the block before every retransmit scenario and before switching mode, and it never starts a write or read before checking the flag the previous edge produced. Overrun and underrun attempts are made on purpose against a full or empty buffer. Their effect is then judged through the data that comes out afterwards.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        WS_LOWER = 2'd0,
        WS_UPPER = 2'd1,
        WS_FULL  = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_EMPTY  = 2'd0,
        RS_DATA   = 2'd1,
        RS_REWIND = 2'd2
    } rd_state_e;

endpackage

// File: rtl/rtx_fifo_mem.sv
module rtx_fifo_mem #(
    parameter int W     = 9,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // registered read port, cleared by reset
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/rtx_gray_xfer.sv
module rtx_gray_xfer #(
    parameter int W = 9
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_bin,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] src_gray;
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    // Gray code registered in the source domain so only one bit moves per step
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            src_gray <= '0;
        end else begin
            src_gray <= src_bin ^ (src_bin >> 1);
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= src_gray;
            safe_q <= meta_q;
        end
    end

    // back to binary: each bit is the parity of the Gray bits at and above it
    for (genvar b = 0; b < W; b++) begin : g_unscramble
        assign dst_bin[b] = ^safe_q[W-1:b];
    end

endmodule

// File: rtl/rtx_fifo_wctl.sv
module rtx_fifo_wctl
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          link_en,
    input  logic [PW-1:0] rptr_sync,
    output logic [PW-1:0] wptr,
    output logic          wr_go,
    output logic          full,
    output logic          half,
    output logic          xo
);

    localparam logic [PW-1:0] CAP  = PW'(DEPTH);
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

    wr_state_e     st, st_nx;
    logic [PW-1:0] wptr_nx;
    logic [PW-1:0] occ_nx;
    logic          xo_q, xo_nx;

    assign wr_go = !wr_n && (st != WS_FULL);

    always_comb begin
        wptr_nx = wptr + {{(PW-1){1'b0}}, wr_go};
        occ_nx  = wptr_nx - rptr_sync;
        xo_nx   = link_en && wr_go && (occ_nx == CAP);
        st_nx   = st;
        unique case (st)
            WS_LOWER: begin
                // lower-to-full only after a rewind inflates the occupancy
                if (occ_nx == CAP)      st_nx = WS_FULL;
                else if (occ_nx > HALF) st_nx = WS_UPPER;
            end
            WS_UPPER: begin
                if (occ_nx == CAP)       st_nx = WS_FULL;
                else if (occ_nx <= HALF) st_nx = WS_LOWER;
            end
            WS_FULL: begin
                if (occ_nx <= HALF)     st_nx = WS_LOWER;
                else if (occ_nx != CAP) st_nx = WS_UPPER;
            end
            default: st_nx = WS_LOWER;
        endcase
    end

    // state register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= WS_LOWER;
            wptr <= '0;
            xo_q <= 1'b0;
        end else begin
            st   <= st_nx;
            wptr <= wptr_nx;
            xo_q <= xo_nx;
        end
    end

    // outputs
    always_comb begin
        full = (st == WS_FULL);
        half = (st != WS_LOWER);
        xo   = xo_q;
    end

    AST_NO_OVERRUN: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && !wr_n) |=> $stable(wptr)); // R4

    AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> (wptr == $past(wptr) || wptr == $past(wptr) + 1'b1)); // R2

    AST_XO_SINGLE: assert property (@(posedge wclk) disable iff (!rst_n)
        xo |=> !xo); // R9

endmodule

// File: rtl/rtx_fifo_rctl.sv
module rtx_fifo_rctl
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          rt_n,
    input  logic          link_en,
    input  logic [PW-1:0] wptr_sync,
    output logic [PW-1:0] rptr,
    output logic          rd_go,
    output logic          empty
);

    rd_state_e     st, st_nx;
    logic [PW-1:0] rptr_nx;
    logic          rewind_req;

    assign rewind_req = !rt_n && rd_n && !link_en;
    assign rd_go      = !rd_n && (st == RS_DATA);

    always_comb begin
        st_nx   = st;
        rptr_nx = rptr;
        unique case (st)
            RS_REWIND: begin
                if (!rt_n) begin
                    rptr_nx = '0;
                end else if (wptr_sync == rptr) begin
                    st_nx = RS_EMPTY;
                end else begin
                    st_nx = RS_DATA;
                end
            end
            RS_EMPTY, RS_DATA: begin
                if (rewind_req) begin
                    rptr_nx = '0;
                    st_nx   = RS_REWIND;
                end else begin
                    rptr_nx = rptr + {{(PW-1){1'b0}}, rd_go};
                    st_nx   = (wptr_sync == rptr_nx) ? RS_EMPTY : RS_DATA;
                end
            end
            default: st_nx = RS_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RS_EMPTY;
            rptr <= '0;
        end else begin
            st   <= st_nx;
            rptr <= rptr_nx;
        end
    end

    // outputs
    always_comb begin
        empty = (st != RS_DATA);
    end

    AST_NO_UNDERRUN: assert property (@(posedge rclk) disable iff (!rst_n)
        (empty && !rd_n) |=> $stable(rptr)); // R4

    AST_RPTR_ADV: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_go |=> (rptr == $past(rptr) + 1'b1)); // R3

    AST_REWIND_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        rewind_req |=> (empty && rptr == '0)); // R8

endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [WORD_W-1:0] din,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic              link_en,
    output logic [WORD_W-1:0] q,
    output logic              q_drive,
    output logic              empty,
    output logic              full,
    output logic              hf_xo
);

    logic [PW-1:0]     wptr, rptr, wptr_in_r, rptr_in_w;
    logic              wr_go, rd_go, half, xo;
    logic [WORD_W-1:0] rdata;

    rtx_fifo_wctl #(.DEPTH(DEPTH)) u_wctl (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .wr_n      (wr_n),
        .link_en   (link_en),
        .rptr_sync (rptr_in_w),
        .wptr      (wptr),
        .wr_go     (wr_go),
        .full      (full),
        .half      (half),
        .xo        (xo)
    );

    rtx_fifo_rctl #(.DEPTH(DEPTH)) u_rctl (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .rd_n      (rd_n),
        .rt_n      (rt_n),
        .link_en   (link_en),
        .wptr_sync (wptr_in_r),
        .rptr      (rptr),
        .rd_go     (rd_go),
        .empty     (empty)
    );

    rtx_gray_xfer #(.W(PW)) u_w2r (
        .src_clk (wclk),
        .dst_clk (rclk),
        .rst_n   (rst_n),
        .src_bin (wptr),
        .dst_bin (wptr_in_r)
    );

    rtx_gray_xfer #(.W(PW)) u_r2w (
        .src_clk (rclk),
        .dst_clk (wclk),
        .rst_n   (rst_n),
        .src_bin (rptr),
        .dst_bin (rptr_in_w)
    );

    rtx_fifo_mem #(.W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .wclk  (wclk),
        .we    (wr_go),
        .waddr (wptr[AW-1:0]),
        .wdata (din),
        .rclk  (rclk),
        .rst_n (rst_n),
        .re    (rd_go),
        .raddr (rptr[AW-1:0]),
        .rdata (rdata)
    );

    assign q_drive = !rd_n;
    assign q       = q_drive ? rdata : {WORD_W{1'bz}};
    assign hf_xo   = link_en ? xo : half;

    AST_LINK_NO_HALF: assert property (@(posedge wclk) disable iff (!rst_n)
        (link_en && !xo) |-> !hf_xo); // R9

    AST_FULL_NOT_WRITTEN: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> !wr_go); // R4

endmodule

// File: tb/sim_rtx_fifo.sv
module sim_rtx_fifo;

    localparam int DEPTH = 256;

    logic       wclk = 1'b0, rclk = 1'b0;
    logic       rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, link_en = 1'b0;
    logic [8:0] din = '0;
    wire  [8:0] q;
    logic       q_drive, empty, full, hf_xo;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    logic [8:0] hist[$];

    always #10 wclk = ~wclk;   // 50 MHz write clock
    always #12 rclk = ~rclk;   // unrelated read clock

    rtx_fifo #(.DEPTH(DEPTH)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_n(wr_n), .din(din),
        .rd_n(rd_n), .rt_n(rt_n), .link_en(link_en), .q(q), .q_drive(q_drive),
        .empty(empty), .full(full), .hf_xo(hf_xo)
    );

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 11) & 9'h1ff);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        repeat (3) @(negedge wclk);
        #5 rst_n = 1'b1;
        exp_q.delete();
        hist.delete();
        repeat (3) @(negedge wclk);
    endtask

    // driver: pushes each accepted word into the scoreboard
    task automatic push_word(input logic [8:0] d);
        @(negedge wclk);
        while (full) @(negedge wclk);
        din = d; wr_n = 1'b0;
        exp_q.push_back(d);
        hist.push_back(d);
        @(negedge wclk);
        wr_n = 1'b1;
    endtask

    // monitor: pops the expected word and compares it with q
    task automatic pop_word(input string req);
        logic [8:0] e;
        @(negedge rclk);
        while (empty) @(negedge rclk);
        rd_n = 1'b0;
        @(negedge rclk);
        e = exp_q.pop_front();
        check(q == e, req, q, e);
        rd_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        logic [8:0] q_prev;

        // R10 reset state
        repeat (2) @(negedge wclk);
        check(empty == 1'b1, "R10 empty", empty, 1);
        check(full == 1'b0, "R10 full", full, 0);
        check(hf_xo == 1'b0, "R10 hf_xo", hf_xo, 0);
        #5 rst_n = 1'b1;
        repeat (3) @(negedge wclk);

        // R5 output floats while rd_n high
        check(q_drive == 1'b0, "R5 idle drive", q_drive, 0);

        // R4 underrun attempt
        @(negedge rclk);
        q_prev = 9'h000;
        rd_n = 1'b0;
        @(negedge rclk);
        check(q_drive == 1'b1, "R5 drive on rd_n", q_drive, 1);
        check(empty == 1'b1, "R4 empty held", empty, 1);
        check(q == q_prev, "R10 R4 q unchanged", q, q_prev);
        rd_n = 1'b1;
        push_word(9'h155);
        pop_word("R4 pointer not moved");

        // R1 R2 R3 concurrent stream
        fork
            for (int i = 0; i < 40; i++) push_word(pat(i));
            for (int j = 0; j < 40; j++) pop_word("R1 R3 stream order");
        join
        repeat (4) @(negedge rclk);
        check(empty == 1'b1, "R6 empty after drain", empty, 1);

        // R7 half-full threshold, R6 full
        repeat (6) @(negedge wclk);
        for (int i = 0; i < DEPTH; i++) begin
            push_word(pat(i + 100));
            if (i == DEPTH/2 - 1) check(hf_xo == 1'b0, "R7 at half", hf_xo, 0);
            if (i == DEPTH/2)     check(hf_xo == 1'b1, "R7 above half", hf_xo, 1);
            if (i == DEPTH - 2)   check(full == 1'b0, "R6 one free", full, 0);
        end
        check(full == 1'b1, "R6 full", full, 1);

        // R4 overrun attempt
        @(negedge wclk);
        din = 9'h0aa; wr_n = 1'b0;
        @(negedge wclk);
        wr_n = 1'b1;
        check(full == 1'b1, "R4 full held", full, 1);
        for (int i = 0; i < DEPTH; i++) pop_word("R4 overrun blocked");
        check(empty == 1'b1, "R6 empty on last read", empty, 1);
        repeat (6) @(negedge wclk);
        check(full == 1'b0, "R6 full cleared", full, 0);
        check(hf_xo == 1'b0, "R7 below half", hf_xo, 0);

        // R8 retransmit
        do_reset();
        for (int i = 0; i < 10; i++) push_word(pat(i + 300));
        for (int i = 0; i < 4; i++) pop_word("R1 before rewind");
        @(negedge rclk);
        rt_n = 1'b0;
        @(negedge rclk);
        check(empty == 1'b1, "R8 empty during rewind", empty, 1);
        repeat (2) @(negedge rclk);
        rt_n = 1'b1;
        exp_q = hist;
        for (int i = 0; i < 10; i++) pop_word("R8 replay");
        repeat (4) @(negedge rclk);
        check(empty == 1'b1, "R8 empty after replay", empty, 1);

        // R9 chain mode
        link_en = 1'b1;
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            push_word(pat(i + 500));
            if (i == DEPTH/2)   check(hf_xo == 1'b0, "R9 no half flag", hf_xo, 0);
            if (i == DEPTH - 2) check(hf_xo == 1'b0, "R9 before fill", hf_xo, 0);
            if (i == DEPTH - 1) check(hf_xo == 1'b1, "R9 hand-off pulse", hf_xo, 1);
        end
        @(negedge wclk);
        check(hf_xo == 1'b0, "R9 pulse ends", hf_xo, 0);
        for (int i = 0; i < 3; i++) pop_word("R9 pre");
        @(negedge rclk);
        rt_n = 1'b0;
        @(negedge rclk);
        check(empty == 1'b0, "R9 rt_n ignored", empty, 0);
        repeat (2) @(negedge rclk);
        rt_n = 1'b1;
        for (int i = 3; i < DEPTH; i++) pop_word("R9 no rewind");
        link_en = 1'b0;
        do_reset();

        summary();
        $finish;
    end

endmodule